// File: doc/BRIEF.md
# Receive Event Classifier with Per-Port Statistics

This block sits behind a receive front end that has already measured each receive event on one of nine ports. For every event it gets a single summary record: the port, how long the activity lasted in bit times, the frame length in octets, whether the CRC was good, whether the bit count was not a whole number of octets, whether a collision happened and at which bit the collision started. The block sorts the event into repeater-management categories and bumps the matching 32-bit counters of that port.

Each port owns nine counters: readable frames, readable octets, FCS errors, alignment errors, frames too long, short events, runts, collisions and late events. Any counter can be read at any time through a combinational read port addressed by port and counter index. Records pass through one registered classification stage, and the counters update on the following edge. One record is accepted every clock, and records for the same port in consecutive cycles are all counted.

Top module: `frame_event_counters`

## Requirements
- R1: A record with no collision, a duration of at least RUNT_BITS (512), a length from MIN_LEN (64) to MAX_LEN (1518) inclusive and a good CRC increments readable frames (index 0) by one and adds its length to readable octets (index 1), modulo 2^32.
- R2: A record that meets R1's duration and length conditions with no collision, a bad CRC and no framing error increments FCS errors (index 2) only.
- R3: A record that meets R1's duration and length conditions with no collision, a bad CRC and a framing error increments alignment errors (index 3) and never FCS errors.
- R4: A record with no collision, a duration of at least RUNT_BITS and a length above MAX_LEN increments frames too long (index 4).
- R5: A record whose duration is below SHORT_BITS (76) increments short events (index 5), with or without a collision.
- R6: A record whose duration is at least SHORT_BITS and below RUNT_BITS increments runts (index 6). A record that counts as a short event never counts as a runt.
- R7: Any record with the collision flag set increments collisions (index 7). Frame-level counters (indices 0 to 4) never move for such a record.
- R8: A collision whose start position is at least LATE_BITS (512) also increments late events (index 8). A collision that starts earlier does not.
- R9: A record whose port number is NPORTS (9) or more changes no counter.
- R10: rd_data returns the counter chosen by rd_port and rd_idx (index codes as in R1 to R8), and returns zero for a port of NPORTS or more or an index of 9 or more. A record presented before clock edge k is visible on rd_data after edge k+1.
- R11: Counters are not cleared by reset, and records presented while rst_n is low are dropped.
- R12: Records for the same port on consecutive cycles are all counted, and every counter other than readable octets moves by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the record stage |
| ev_valid | input | 1 | A record is presented this cycle |
| ev_port | input | PORT_W (4) | Port the record belongs to |
| ev_dur | input | DUR_W (16) | Activity duration in bit times |
| ev_len | input | LEN_W (16) | Frame length in octets |
| ev_crc_ok | input | 1 | CRC check passed |
| ev_frame_err | input | 1 | Bit count was not a whole number of octets |
| ev_coll | input | 1 | A collision occurred during the event |
| ev_coll_pos | input | DUR_W (16) | Bit position where the collision began |
| rd_port | input | PORT_W (4) | Port of the counter to read |
| rd_idx | input | 4 | Counter index to read |
| rd_data | output | 32 | Selected counter value |

## Verification
The bench builds the block with its defaults: nine ports, 16-bit duration and length fields, a short-event limit of 76, runt and late thresholds of 512 and a frame length window of 64 to 1518. With these field widths the directed cases can sit exactly on each boundary (75/76, 511/512, 63/64, 1518/1519), and the port field still has room for codes 9 to 15, which exercise the dropped-record path. Since the counters start unknown, the bench first takes a snapshot of every counter and then checks the changes. The random records cover all ports, both flags and lengths up to 1600 octets.

// File: rtl/fec_pkg.sv
package fec_pkg;

    localparam int CNT_W   = 32;
    localparam int NUM_CNT = 9;
    localparam int IDX_W   = 4;

    typedef enum logic [IDX_W-1:0] {
        CI_RDFRM = 4'd0,
        CI_RDOCT = 4'd1,
        CI_FCS   = 4'd2,
        CI_ALIGN = 4'd3,
        CI_LONG  = 4'd4,
        CI_SHORT = 4'd5,
        CI_RUNT  = 4'd6,
        CI_COLL  = 4'd7,
        CI_LATE  = 4'd8
    } cnt_idx_e;

endpackage

// File: rtl/fec_classify.sv
module fec_classify
    import fec_pkg::*;
#(
    parameter int DUR_W      = 16,
    parameter int LEN_W      = 16,
    parameter int SHORT_BITS = 76,
    parameter int RUNT_BITS  = 512,
    parameter int LATE_BITS  = 512,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518
) (
    input  logic [DUR_W-1:0]   dur,
    input  logic [LEN_W-1:0]   len,
    input  logic               crc_ok,
    input  logic               frame_err,
    input  logic               coll,
    input  logic [DUR_W-1:0]   coll_pos,
    output logic [NUM_CNT-1:0] inc
);

    localparam logic [DUR_W-1:0] SHORT_L = DUR_W'(SHORT_BITS);
    localparam logic [DUR_W-1:0] RUNT_L  = DUR_W'(RUNT_BITS);
    localparam logic [DUR_W-1:0] LATE_L  = DUR_W'(LATE_BITS);
    localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_LEN);

    logic frame_eligible;

    always_comb begin
        inc            = '0;
        frame_eligible = !coll && (dur >= RUNT_L);

        // duration windows
        if (dur < SHORT_L) begin
            inc[CI_SHORT] = 1'b1;
        end else if (dur < RUNT_L) begin
            inc[CI_RUNT] = 1'b1;
        end

        // collision accounting
        if (coll) begin
            inc[CI_COLL] = 1'b1;
            if (coll_pos >= LATE_L) begin
                inc[CI_LATE] = 1'b1;
            end
        end

        // frame-level categories
        if (frame_eligible) begin
            if (len > MAX_L) begin
                inc[CI_LONG] = 1'b1;
            end else if (len >= MIN_L) begin
                if (crc_ok) begin
                    inc[CI_RDFRM] = 1'b1;
                    inc[CI_RDOCT] = 1'b1;
                end else if (frame_err) begin
                    inc[CI_ALIGN] = 1'b1;
                end else begin
                    inc[CI_FCS] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        a_fcs_align_excl_r3: assert (!(inc[CI_FCS] && inc[CI_ALIGN]));
        a_short_runt_excl_r6: assert (!(inc[CI_SHORT] && inc[CI_RUNT]));
        a_late_needs_coll_r8: assert (!inc[CI_LATE] || coll);
        a_readable_no_coll_r7: assert (!(coll && (inc[CI_RDFRM] || inc[CI_FCS] || inc[CI_ALIGN] || inc[CI_LONG])));
    end

endmodule

// File: rtl/fec_port_bank.sv
module fec_port_bank
    import fec_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             hit,
    input  logic [NUM_CNT-1:0]               inc,
    input  logic [LEN_W-1:0]                 len,
    output logic [NUM_CNT-1:0][CNT_W-1:0]    cnt
);

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        logic [CNT_W-1:0] step;

        if (c == int'(CI_RDOCT)) begin : g_oct
            assign step = CNT_W'(len);
        end else begin : g_unit
            assign step = CNT_W'(1);

            p_step_unit_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q[c] - $past(cnt_q[c])) <= CNT_W'(1));
        end

        // deliberately no reset: statistics survive a reset
        always_ff @(posedge clk) begin
            if (hit && inc[c]) begin
                cnt_q[c] <= cnt_q[c] + step;
            end
        end

        p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(hit) |-> $stable(cnt_q[c]));
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/frame_event_counters.sv
module frame_event_counters
    import fec_pkg::*;
#(
    parameter int NPORTS     = 9,
    parameter int DUR_W      = 16,
    parameter int LEN_W      = 16,
    parameter int SHORT_BITS = 76,
    parameter int RUNT_BITS  = 512,
    parameter int LATE_BITS  = 512,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518,
    localparam int PORT_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [PORT_W-1:0] ev_port,
    input  logic [DUR_W-1:0]  ev_dur,
    input  logic [LEN_W-1:0]  ev_len,
    input  logic              ev_crc_ok,
    input  logic              ev_frame_err,
    input  logic              ev_coll,
    input  logic [DUR_W-1:0]  ev_coll_pos,
    input  logic [PORT_W-1:0] rd_port,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_data
);

    logic [NUM_CNT-1:0] cls_inc;
    logic               port_ok;

    logic               s_valid;
    logic [PORT_W-1:0]  s_port;
    logic [NUM_CNT-1:0] s_inc;
    logic [LEN_W-1:0]   s_len;

    logic [NPORTS-1:0][NUM_CNT-1:0][CNT_W-1:0] cnt_all;

    fec_classify #(
        .DUR_W      (DUR_W),
        .LEN_W      (LEN_W),
        .SHORT_BITS (SHORT_BITS),
        .RUNT_BITS  (RUNT_BITS),
        .LATE_BITS  (LATE_BITS),
        .MIN_LEN    (MIN_LEN),
        .MAX_LEN    (MAX_LEN)
    ) u_cls (
        .dur       (ev_dur),
        .len       (ev_len),
        .crc_ok    (ev_crc_ok),
        .frame_err (ev_frame_err),
        .coll      (ev_coll),
        .coll_pos  (ev_coll_pos),
        .inc       (cls_inc)
    );

    assign port_ok = ({1'b0, ev_port} < (PORT_W+1)'(NPORTS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_port  <= '0;
            s_inc   <= '0;
            s_len   <= '0;
        end else begin
            s_valid <= ev_valid && port_ok;
            s_port  <= ev_port;
            s_inc   <= cls_inc;
            s_len   <= ev_len;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        fec_port_bank #(
            .LEN_W (LEN_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (s_valid && (s_port == PORT_W'(p))),
            .inc   (s_inc),
            .len   (s_len),
            .cnt   (cnt_all[p])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPORTS; p++) begin
            for (int c = 0; c < NUM_CNT; c++) begin
                if (rd_port == PORT_W'(p) && rd_idx == IDX_W'(c)) begin
                    rd_data = cnt_all[p][c];
                end
            end
        end
    end

    p_stage_port_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> ({1'b0, s_port} < (PORT_W+1)'(NPORTS)));

    p_reset_drops_r11: assert property (@(posedge clk)
        !rst_n |=> !s_valid);

endmodule

// File: tb/tb_frame_event_counters.sv
module tb_frame_event_counters;

    localparam int CLK_P  = 10;
    localparam int NP     = 9;
    localparam int NC     = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_port = '0;
    logic [15:0] ev_dur = '0;
    logic [15:0] ev_len = '0;
    logic        ev_crc_ok = 1'b0;
    logic        ev_frame_err = 1'b0;
    logic        ev_coll = 1'b0;
    logic [15:0] ev_coll_pos = '0;
    logic [3:0]  rd_port = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NP][NC];

    always #(CLK_P/2) clk = ~clk;

    frame_event_counters dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_port(ev_port),
        .ev_dur(ev_dur), .ev_len(ev_len), .ev_crc_ok(ev_crc_ok),
        .ev_frame_err(ev_frame_err), .ev_coll(ev_coll), .ev_coll_pos(ev_coll_pos),
        .rd_port(rd_port), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [NC-1:0] exp_mask(int dur, int len, bit crc, bit fe, bit col, int cp);
        logic [NC-1:0] m = '0;
        if (dur < 76) m[5] = 1'b1;
        else if (dur < 512) m[6] = 1'b1;
        if (col) begin
            m[7] = 1'b1;
            if (cp >= 512) m[8] = 1'b1;
        end
        if (!col && dur >= 512) begin
            if (len > 1518) m[4] = 1'b1;
            else if (len >= 64) begin
                if (crc) begin m[0] = 1'b1; m[1] = 1'b1; end
                else if (fe) m[3] = 1'b1;
                else m[2] = 1'b1;
            end
        end
        return m;
    endfunction

    // called at a falling edge; leaves the record valid for exactly one rising edge
    task automatic send(int port, int dur, int len, bit crc, bit fe, bit col, int cp);
        logic [NC-1:0] m;
        ev_valid = 1'b1; ev_port = 4'(port); ev_dur = 16'(dur); ev_len = 16'(len);
        ev_crc_ok = crc; ev_frame_err = fe; ev_coll = col; ev_coll_pos = 16'(cp);
        m = exp_mask(dur, len, crc, fe, col, cp);
        if (rst_n && port < NP) begin
            for (int c = 0; c < NC; c++) begin
                if (m[c]) model[port][c] = model[port][c] + ((c == 1) ? 32'(len) : 32'd1);
            end
        end
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic check_val(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < NC; c++) begin
                rd_port = 4'(p); rd_idx = 4'(c);
                #1;
                check_val($sformatf("%s port %0d idx %0d", tag, p, c), rd_data, model[p][c]);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // snapshot of the unknown start values
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < NC; c++) begin
                rd_port = 4'(p); rd_idx = 4'(c);
                #1;
                model[p][c] = rd_data;
            end
        end
        @(negedge clk);
        check_all("R11 no spurious change after reset");

        // R10 latency: visible after the second rising edge, not after the first
        send(2, 600, 100, 1, 0, 0, 0);
        rd_port = 4'd2; rd_idx = 4'd0; #1;
        check_val("R10 not yet visible after one edge", rd_data, model[2][0] - 32'd1);
        @(negedge clk); #1;
        check_val("R10 visible after two edges", rd_data, model[2][0]);

        send(0, 600, 64, 1, 0, 0, 0);
        send(1, 600, 1518, 1, 0, 0, 0);
        check_all("R1 readable bounds");
        send(3, 600, 200, 0, 0, 0, 0);
        check_all("R2 fcs error");
        send(4, 600, 200, 0, 1, 0, 0);
        check_all("R3 alignment error");
        send(5, 600, 1519, 1, 0, 0, 0);
        send(5, 600, 63, 0, 0, 0, 0);
        check_all("R4 too long and undersize");
        send(6, 75, 10, 1, 0, 0, 0);
        send(6, 40, 10, 1, 0, 1, 20);
        check_all("R5 short events");
        send(7, 76, 10, 1, 0, 0, 0);
        send(7, 511, 63, 1, 0, 0, 0);
        send(7, 512, 30, 1, 0, 0, 0);
        check_all("R6 runt window");
        send(8, 700, 200, 1, 0, 1, 511);
        check_all("R7 collision not late");
        send(8, 700, 200, 1, 0, 1, 512);
        check_all("R8 late collision");
        send(9, 600, 100, 1, 0, 0, 0);
        send(15, 50, 100, 0, 0, 1, 600);
        check_all("R9 bad port dropped");

        rd_port = 4'd0; rd_idx = 4'd9; #1;
        check_val("R10 index out of range", rd_data, 32'd0);
        rd_port = 4'd9; rd_idx = 4'd0; #1;
        check_val("R10 port out of range", rd_data, 32'd0);
        @(negedge clk);

        // R12 back-to-back records on one port
        for (int i = 0; i < 6; i++) send(1, 600, 100 + i, (i % 2) == 0, 0, i == 5, 600);
        check_all("R12 back-to-back");

        // R11 counters survive reset; records during reset dropped
        rst_n = 1'b0;
        send(0, 600, 100, 1, 0, 0, 0);
        send(3, 50, 100, 0, 0, 1, 700);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_all("R11 reset keeps counters");

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 9) < 7) begin
                send($urandom_range(0, 10), $urandom_range(0, 1700), $urandom_range(30, 1600),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     $urandom_range(0, 3) == 0, $urandom_range(400, 620));
            end else begin
                @(negedge clk);
            end
        end
        check_all("R1 R2 R3 R4 R5 R6 R7 R8 R12 random mix");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule